// File: doc/BRIEF.md
# Receive ring packet writer

This block stores incoming Ethernet frames in a circular region of an 8-bit buffer memory. Each frame arrives as a byte stream. It carries a last-byte marker and a good/bad flag that is valid with the last byte. The block first writes the payload bytes, starting six bytes past the current write base. Once the frame has ended, it fills those six reserved bytes with a header. The header holds the address of the next slot, the byte count and a status word. The next slot is always rounded up to an even address, and addresses wrap from the top of the region back to its bottom, even in the middle of a frame.

The host drains the ring at its own pace. It publishes the address up to which it has consumed data on `host_rdptr`, and it pulses `pkt_dec` once for every frame it has finished with. The block keeps a saturating count of stored, unconsumed frames and raises `pkt_pending` while that count is nonzero. A frame that is too long, or whose slot does not fit in front of the host pointer, is dropped. A drop raises `rx_drop` for one cycle and leaves the count and the write base untouched.

After the last byte of a frame, the upstream source must leave at least seven idle cycles, because the header is written during that time. The memory port writes one byte per cycle.

Top module: `rx_ring_writer`

## Requirements
- R1: A stored frame's six header bytes are written at offsets 0..5 from its write base, in this order: next-slot address low byte, high byte, byte count low byte, high byte, status low byte, status high byte.
- R2: The status word has bit 7 equal to `in_ok` sampled with the last byte, and all other bits zero. Frames with `in_ok` low are still stored.
- R3: Payload byte i (counting from 0) is written at offset 6+i from the write base. Every address wraps modulo RING_SIZE inside [RING_START, RING_START+RING_SIZE), and no write falls outside that region.
- R4: The next-slot address is the write base plus 6 plus the length, rounded up to an even number and wrapped. It becomes the write base of the following frame.
- R5: A frame of more than MAX_LEN bytes is dropped. `rx_drop` is high for exactly the cycle after the edge that took the last byte, and neither `pkt_count` nor the write base changes.
- R6: Let room be rd−base when rd>base, and RING_SIZE−(base−rd) otherwise. A frame is stored only if its padded slot size is strictly less than room. Otherwise it is dropped as in R5, and no write lands at an offset of room or more from the base.
- R7: `pkt_count` rises by one on the seventh clock edge after the edge that took the last byte of a stored frame. Each cycle with `pkt_dec` high lowers the count by one, but never below zero. If an increment and a decrement fall on the same edge, the count is unchanged.
- R8: `pkt_count` saturates at 2^CNT_W−1.
- R9: `pkt_pending` is high exactly when `pkt_count` is nonzero.
- R10: After reset, `pkt_count` is 0, `pkt_pending`, `mem_we` and `rx_drop` are low, and the first frame is based at RING_START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame byte present this cycle |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ok | input | 1 | Frame received without error, valid with `in_last` |
| host_rdptr | input | ADDR_W | Host's consumed-through address |
| pkt_dec | input | 1 | Host releases one stored frame |
| mem_we | output | 1 | Buffer memory write enable |
| mem_addr | output | ADDR_W | Buffer memory write address |
| mem_wdata | output | 8 | Buffer memory write data |
| pkt_count | output | CNT_W | Frames stored and not yet released |
| pkt_pending | output | 1 | At least one frame is pending |
| rx_drop | output | 1 | One-cycle pulse when a frame is discarded |

## Verification
The checker watches every cycle for the following: writes stay inside the region, no write reaches past the free space that the host pointer allows, the count moves by at most one step and holds at its ceiling, drops leave the count alone, the pending flag rises only when the count leaves zero, and the write base keeps its even alignment. Other properties are shown only by the bench's scenarios, because they concern memory contents and exact timing. These are the header byte order and values, payload placement across the wrap point, the even-rounded next-slot address, the seven-cycle commit latency, the cancelling of an increment against a decrement, and the exact boundary where a slot stops fitting.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int unsigned HDR_BYTES = 6;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DATA   = 2'd1,
    ST_HDR    = 2'd2,
    ST_COMMIT = 2'd3
  } rxr_state_e;

  // base + off, folded back into [start, start+size); off must stay below size
  function automatic int unsigned ring_step(int unsigned base, int unsigned off,
                                            int unsigned start, int unsigned size);
    int unsigned sum;
    sum = base + off;
    if (sum >= start + size) sum = sum - size;
    return sum;
  endfunction

  // bytes free ahead of the write base; equal pointers mean the ring is empty
  function automatic int unsigned ring_room(int unsigned wr, int unsigned rd,
                                            int unsigned size);
    return (rd > wr) ? (rd - wr) : (size - (wr - rd));
  endfunction

  // header plus payload, rounded up to an even byte count
  function automatic int unsigned slot_len(int unsigned len);
    return (HDR_BYTES + len + 32'd1) & ~32'd1;
  endfunction

endpackage

// File: rtl/rxr_space.sv
module rxr_space #(
  parameter int ADDR_W    = 13,
  parameter int RING_SIZE = 6144,
  parameter int MAX_LEN   = 1518,
  parameter int IDX_W     = 11
) (
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [ADDR_W-1:0] rd_ptr,
  input  logic [IDX_W-1:0]  cur_idx,
  output logic              byte_fits,
  output logic              slot_fits,
  output logic              idx_over
);
  import rxr_pkg::*;

  logic [31:0] room;

  always_comb begin
    room      = ring_room(32'(wr_base), 32'(rd_ptr), RING_SIZE);
    // keep one byte between the newest write and the host pointer
    byte_fits = (HDR_BYTES + 32'(cur_idx) + 32'd1) < room;
    slot_fits = slot_len(32'(cur_idx) + 32'd1) < room;
    idx_over  = 32'(cur_idx) >= MAX_LEN;
  end

endmodule

// File: rtl/rxr_hdr.sv
module rxr_hdr #(
  parameter int ADDR_W     = 13,
  parameter int LEN_W      = 11,
  parameter int RING_START = 0,
  parameter int RING_SIZE  = 6144
) (
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              frame_ok,
  input  logic [2:0]        hdr_idx,
  output logic [ADDR_W-1:0] next_base,
  output logic [ADDR_W-1:0] hdr_addr,
  output logic [7:0]        hdr_byte
);
  import rxr_pkg::*;

  logic [15:0] nxt_word;
  logic [15:0] len_word;
  logic [15:0] stat_word;

  always_comb begin
    next_base = ADDR_W'(ring_step(32'(wr_base), slot_len(32'(frame_len)),
                                  RING_START, RING_SIZE));
    hdr_addr  = ADDR_W'(ring_step(32'(wr_base), 32'(hdr_idx),
                                  RING_START, RING_SIZE));
    nxt_word  = 16'(next_base);
    len_word  = 16'(frame_len);
    stat_word = {8'h00, frame_ok, 7'h00};
    // byte order is decoded by the host: pointer, count, status, low byte first
    case (hdr_idx)
      3'd0:    hdr_byte = nxt_word[7:0];
      3'd1:    hdr_byte = nxt_word[15:8];
      3'd2:    hdr_byte = len_word[7:0];
      3'd3:    hdr_byte = len_word[15:8];
      3'd4:    hdr_byte = stat_word[7:0];
      3'd5:    hdr_byte = stat_word[15:8];
      default: hdr_byte = 8'h00;
    endcase
  end

endmodule

// File: rtl/rxr_pktcnt.sv
module rxr_pktcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (inc && !dec) begin
      if (count != CNT_MAX) count <= count + 1'b1;
    end else if (dec && !inc) begin
      if (count != '0) count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int ADDR_W     = 13,
  parameter int RING_START = 0,
  parameter int RING_SIZE  = 6144,
  parameter int MAX_LEN    = 1518,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              in_ok,
  input  logic [ADDR_W-1:0] host_rdptr,
  input  logic              pkt_dec,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [CNT_W-1:0]  pkt_count,
  output logic              pkt_pending,
  output logic              rx_drop
);
  import rxr_pkg::*;

  localparam int IDX_W = $clog2(MAX_LEN + 1);
  localparam int LEN_W = $clog2(MAX_LEN + 2);
  localparam logic [2:0] HDR_LAST = 3'(HDR_BYTES - 1);

  rxr_state_e        state;
  logic [IDX_W-1:0]  byte_cnt;
  logic              spoiled;
  logic [LEN_W-1:0]  frame_len;
  logic              frame_ok;
  logic [2:0]        hdr_idx;
  logic [ADDR_W-1:0] wr_base;

  // named internal events, also observed by the checker
  logic              accept;
  logic              byte_fits;
  logic              slot_fits;
  logic              idx_over;
  logic              data_wr;
  logic              drop_now;
  logic              commit;
  logic [ADDR_W-1:0] data_addr;
  logic [ADDR_W-1:0] next_base;
  logic [ADDR_W-1:0] hdr_addr;
  logic [7:0]        hdr_byte;

  rxr_space #(
    .ADDR_W(ADDR_W), .RING_SIZE(RING_SIZE), .MAX_LEN(MAX_LEN), .IDX_W(IDX_W)
  ) u_space (
    .wr_base(wr_base), .rd_ptr(host_rdptr), .cur_idx(byte_cnt),
    .byte_fits(byte_fits), .slot_fits(slot_fits), .idx_over(idx_over)
  );

  rxr_hdr #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .RING_START(RING_START), .RING_SIZE(RING_SIZE)
  ) u_hdr (
    .wr_base(wr_base), .frame_len(frame_len), .frame_ok(frame_ok),
    .hdr_idx(hdr_idx), .next_base(next_base), .hdr_addr(hdr_addr),
    .hdr_byte(hdr_byte)
  );

  rxr_pktcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(commit), .dec(pkt_dec), .count(pkt_count)
  );

  always_comb begin
    accept    = in_valid && (state == ST_IDLE || state == ST_DATA);
    data_wr   = accept && !spoiled && !idx_over && byte_fits;
    drop_now  = spoiled || idx_over || !byte_fits || !slot_fits;
    commit    = (state == ST_COMMIT);
    data_addr = ADDR_W'(ring_step(32'(wr_base), HDR_BYTES + 32'(byte_cnt),
                                  RING_START, RING_SIZE));
  end

  assign pkt_pending = (pkt_count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      byte_cnt  <= '0;
      spoiled   <= 1'b0;
      frame_len <= '0;
      frame_ok  <= 1'b0;
      hdr_idx   <= '0;
      wr_base   <= ADDR_W'(RING_START);
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rx_drop   <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      rx_drop <= 1'b0;
      case (state)
        ST_IDLE, ST_DATA: begin
          if (accept) begin
            mem_we    <= data_wr;
            mem_addr  <= data_addr;
            mem_wdata <= in_data;
            if (in_last) begin
              byte_cnt <= '0;
              spoiled  <= 1'b0;
              if (drop_now) begin
                rx_drop <= 1'b1;
                state   <= ST_IDLE;
              end else begin
                frame_len <= LEN_W'(byte_cnt) + 1'b1;
                frame_ok  <= in_ok;
                hdr_idx   <= '0;
                state     <= ST_HDR;
              end
            end else begin
              state    <= ST_DATA;
              spoiled  <= spoiled || idx_over || !byte_fits;
              if (!idx_over) byte_cnt <= byte_cnt + 1'b1;
            end
          end
        end
        ST_HDR: begin
          mem_we    <= 1'b1;
          mem_addr  <= hdr_addr;
          mem_wdata <= hdr_byte;
          if (hdr_idx == HDR_LAST) state <= ST_COMMIT;
          else hdr_idx <= hdr_idx + 1'b1;
        end
        ST_COMMIT: begin
          wr_base <= next_base;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int ADDR_W     = 13,
  parameter int RING_START = 0,
  parameter int RING_SIZE  = 6144,
  parameter int CNT_W      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_rdptr,
  input logic              pkt_dec,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [CNT_W-1:0]  pkt_count,
  input logic              pkt_pending,
  input logic              rx_drop,
  input logic [ADDR_W-1:0] wr_base
);
  import rxr_pkg::*;

  localparam logic [ADDR_W:0]  LO_LIM    = (ADDR_W+1)'(RING_START);
  localparam logic [ADDR_W:0]  HI_LIM    = (ADDR_W+1)'(RING_START + RING_SIZE);
  localparam logic [CNT_W-1:0] CNT_TOP   = '1;
  localparam logic             BASE_PAR  = 1'(RING_START % 2);

  logic [ADDR_W-1:0] rd_q;
  logic [31:0]       wr_off;
  logic [31:0]       room_q;

  always_ff @(posedge clk) rd_q <= host_rdptr;

  always_comb begin
    wr_off = (mem_addr >= wr_base) ? (32'(mem_addr) - 32'(wr_base))
                                   : (32'(mem_addr) + RING_SIZE - 32'(wr_base));
    room_q = ring_room(32'(wr_base), 32'(rd_q), RING_SIZE);
  end

  AST_ADDR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ({1'b0, mem_addr} >= LO_LIM && {1'b0, mem_addr} < HI_LIM)); // R3

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wr_off < room_q)); // R6

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_count != $past(pkt_count)) |->
      (({1'b0, $past(pkt_count)} + 1'b1 == {1'b0, pkt_count}) ||
       ({1'b0, pkt_count} + 1'b1 == {1'b0, $past(pkt_count)}))); // R7

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pkt_count) == CNT_TOP && !$past(pkt_dec)) |-> (pkt_count == CNT_TOP)); // R8

  AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drop && !$past(pkt_dec)) |-> $stable(pkt_count)); // R5

  AST_PENDING_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_pending) |-> ($past(pkt_count) == '0)); // R9

  AST_BASE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_base[0] == BASE_PAR); // R4

endmodule

bind rx_ring_writer rx_ring_writer_chk #(
  .ADDR_W(ADDR_W), .RING_START(RING_START), .RING_SIZE(RING_SIZE), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/rx_ring_writer_tb.sv
module rx_ring_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 7;
  localparam int RS  = 8;
  localparam int RSZ = 64;
  localparam int ML  = 20;
  localparam int CW  = 8;
  localparam int CTOP = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_last = 1'b0;
  logic in_ok = 1'b0;
  logic [AW-1:0] host_rdptr;
  logic pkt_dec = 1'b0;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [CW-1:0] pkt_count;
  logic pkt_pending;
  logic rx_drop;

  int vectors = 0;
  int fails = 0;
  int base_m = RS;
  int rd_m = RS;
  int count_m = 0;
  bit drop_seen = 1'b0;
  bit done = 1'b0;
  logic [7:0] bmem [0:(1<<AW)-1];

  assign host_rdptr = AW'(rd_m);

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_writer #(
    .ADDR_W(AW), .RING_START(RS), .RING_SIZE(RSZ), .MAX_LEN(ML), .CNT_W(CW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ok(in_ok), .host_rdptr(host_rdptr), .pkt_dec(pkt_dec),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pkt_count(pkt_count), .pkt_pending(pkt_pending), .rx_drop(rx_drop)
  );

  function automatic int wrapb(int a);
    return (a >= RS + RSZ) ? a - RSZ : a;
  endfunction

  function automatic int room_of(int b, int r);
    if (r > b) return r - b;
    return RSZ - (b - r);
  endfunction

  function automatic logic [7:0] pay(int len, int i);
    return 8'((len * 29 + i * 7 + 3) & 255);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // write monitor: region bounds and room against the bench's own pointers
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_drop) drop_seen = 1'b1;
      if (mem_we) begin
        int off;
        int a;
        a = int'(mem_addr);
        bmem[mem_addr] = mem_wdata;
        chk(a >= RS && a < RS + RSZ, "R3 address in region", a, RS);
        off = (a >= base_m) ? a - base_m : a + RSZ - base_m;
        chk(off < room_of(base_m, rd_m), "R6 write within room", off, room_of(base_m, rd_m));
      end
    end
  end

  task automatic run_frame(int len, bit ok, bit dec_at_commit);
    int need;
    int room;
    bit stored;
    int exp_cnt;
    int nxt;
    need = 6 + len;
    if (need % 2 != 0) need++;
    room = room_of(base_m, rd_m);
    stored = (len <= ML) && (need < room);
    drop_seen = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = pay(len, i);
      in_last  = (i == len - 1);
      in_ok    = ok;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    for (int j = 1; j <= 7; j++) begin
      @(negedge clk);
      if (stored) begin
        if (j < 7) exp_cnt = count_m;
        else if (dec_at_commit) exp_cnt = count_m;
        else exp_cnt = (count_m < CTOP) ? count_m + 1 : CTOP;
        chk(int'(pkt_count) == exp_cnt, "R7 count timing", int'(pkt_count), exp_cnt);
      end
      if (dec_at_commit && j == 6) pkt_dec = 1'b1;
      if (dec_at_commit && j == 7) pkt_dec = 1'b0;
    end
    if (!stored) begin
      chk(drop_seen, (len > ML) ? "R5 long frame dropped" : "R6 no room, dropped", int'(drop_seen), 1);
      chk(int'(pkt_count) == count_m, "R5 count unchanged on drop", int'(pkt_count), count_m);
    end else begin
      if (!dec_at_commit && count_m < CTOP) count_m++;
      chk(!drop_seen, "R2 stored frame not dropped", int'(drop_seen), 0);
      nxt = wrapb(base_m + need);
      chk(int'(bmem[AW'(wrapb(base_m + 0))]) == (nxt & 255), "R1 R4 next pointer low",
          int'(bmem[AW'(wrapb(base_m + 0))]), nxt & 255);
      chk(int'(bmem[AW'(wrapb(base_m + 1))]) == (nxt >> 8), "R1 next pointer high",
          int'(bmem[AW'(wrapb(base_m + 1))]), nxt >> 8);
      chk(int'(bmem[AW'(wrapb(base_m + 2))]) == (len & 255), "R1 length low",
          int'(bmem[AW'(wrapb(base_m + 2))]), len & 255);
      chk(int'(bmem[AW'(wrapb(base_m + 3))]) == (len >> 8), "R1 length high",
          int'(bmem[AW'(wrapb(base_m + 3))]), len >> 8);
      chk(int'(bmem[AW'(wrapb(base_m + 4))]) == (ok ? 128 : 0), "R2 status low",
          int'(bmem[AW'(wrapb(base_m + 4))]), ok ? 128 : 0);
      chk(int'(bmem[AW'(wrapb(base_m + 5))]) == 0, "R2 status high",
          int'(bmem[AW'(wrapb(base_m + 5))]), 0);
      for (int i = 0; i < len; i++) begin
        chk(bmem[AW'(wrapb(base_m + 6 + i))] == pay(len, i), "R3 payload byte",
            int'(bmem[AW'(wrapb(base_m + 6 + i))]), int'(pay(len, i)));
      end
      base_m = nxt;
    end
  endtask

  task automatic release_frames(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      pkt_dec = 1'b1;
      @(negedge clk);
      pkt_dec = 1'b0;
      if (count_m > 0) count_m--;
      chk(int'(pkt_count) == count_m, "R7 decrement", int'(pkt_count), count_m);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(int'(pkt_count) == 0, "R10 count after reset", int'(pkt_count), 0);
    chk(!pkt_pending, "R10 pending after reset", int'(pkt_pending), 0);
    chk(!mem_we, "R10 no write after reset", int'(mem_we), 0);
    chk(!rx_drop, "R10 no drop after reset", int'(rx_drop), 0);
    // R7 release at zero has no effect
    release_frames(1);

    // sweep every legal length, host consuming each frame right away
    for (int len = 1; len <= ML; len++) begin
      run_frame(len, (len % 3) != 0, 1'b0);
      chk(pkt_pending, "R9 pending with one frame", int'(pkt_pending), 1);
      rd_m = base_m;
      release_frames(1);
      chk(!pkt_pending, "R9 pending cleared", int'(pkt_pending), 0);
    end

    // R5 over-length frames, then a good frame at the unchanged base
    run_frame(ML + 1, 1'b1, 1'b0);
    run_frame(ML + 7, 1'b1, 1'b0);
    run_frame(5, 1'b1, 1'b0);
    rd_m = base_m;
    release_frames(1);

    // R6 fill the ring against a fixed host pointer, probe the exact boundary
    run_frame(10, 1'b1, 1'b0);
    run_frame(10, 1'b0, 1'b0);
    run_frame(10, 1'b1, 1'b0);
    run_frame(10, 1'b1, 1'b0);
    run_frame(9, 1'b1, 1'b0);
    run_frame(8, 1'b1, 1'b0);
    run_frame(1, 1'b1, 1'b0);
    rd_m = base_m;
    release_frames(count_m);

    // R7 increment and release on the same edge cancel
    run_frame(3, 1'b1, 1'b0);
    run_frame(4, 1'b1, 1'b1);
    rd_m = base_m;
    release_frames(count_m);

    // R8 saturation: host frees space but never releases
    for (int k = 0; k < CTOP + 3; k++) begin
      run_frame(1, 1'b1, 1'b0);
      rd_m = base_m;
    end
    chk(int'(pkt_count) == CTOP, "R8 count saturated", int'(pkt_count), CTOP);
    release_frames(1);
    chk(pkt_pending, "R9 pending while nonzero", int'(pkt_pending), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule